// File: doc/BRIEF.md
# Multi-Channel ISA DMA Request Controller

This block runs the DMA request/acknowledge handshake between a set of internal data paths (three by default, called A, B and C) and the 8-bit ISA DMA channels 0 to 3. An internal path raises a one-cycle request pulse together with a byte count. The block then holds the DRQ line of the ISA channel that the path is routed to. It keeps that line high until the host DMA controller has moved the whole burst, one byte per IOR or IOW strobe issued while the channel's DACK is high.

Bytes written by the host (IOW) are handed to the path's FIFO as push pulses with data. Bytes read by the host (IOR) are taken from the path's FIFO output and produce pop pulses. A path pulses its completion flag when its burst ends. A routing register decides which ISA channel each path uses. Full-duplex operation uses two paths routed to separate channels, with one path for playback and the other for capture. Routing two paths onto one channel is reported as a configuration error.

Top module: `isa_dma_reqctl`

## Requirements
- R1: After reset, every DRQ output, done flag, push and pop pulse is low and `cfg_err` is low. The routing then maps path A to channel 0, path B to channel 1 and path C to channel 3.
- R2: A request pulse on path p, sampled at a clock edge while the path is idle, raises the DRQ of its channel from that edge onward. A length field of value L asks for L+1 bytes.
- R3: A byte is counted at the trailing edge of IOR or IOW, which is the first cycle the strobe is seen low after being high. The channel's DACK must have been high in the cycle before that edge. DRQ stays high until L+1 bytes have been counted.
- R4: DRQ falls and the path's done flag pulses for one cycle in the very cycle the final trailing edge is seen, so no further byte is requested.
- R5: A strobe that is not accompanied by DACK, or that falls on a channel with no active burst, counts no byte and produces no push, pop or done.
- R6: At the trailing edge of an IOW byte, `push[p]` pulses and `push_data` equals the `bus_din` value last sampled while IOW was high.
- R7: While IOR and the DACK of an owned, busy channel are high, `bus_oe` is high and `bus_dout` carries that path's `pop_data` byte. `pop[p]` pulses at the trailing edge.
- R8: A request that arrives on a busy path is stored in a single queue slot. Its burst starts in the cycle after the current burst ends, and DRQ is high again from then on. Further requests made while the slot is full are ignored.
- R9: A one-cycle `route_we` loads `route_wdata`. Bits [2p+1:2p] hold the channel number, 0 to 3, of path p.
- R10: If two paths share a channel, `cfg_err` is high and the lower-lettered path keeps the channel. Requests on the losing path are ignored and never raise any DRQ.
- R11: Paths on distinct channels run concurrently and independently. Bytes on one channel never change another path's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_we | input | 1 | Load routing register |
| route_wdata | input | 6 | Channel number per path, 2 bits each |
| req | input | 3 | Request pulse per path |
| req_len | input | 24 | Byte count minus one per path, 8 bits each |
| dack | input | 4 | DMA acknowledge per ISA channel, active high |
| ior | input | 1 | I/O read strobe, active high, synchronous |
| iow | input | 1 | I/O write strobe, active high, synchronous |
| bus_din | input | 8 | Data from the host during IOW |
| bus_dout | output | 8 | Data to the host during IOR |
| bus_oe | output | 1 | Drive enable for bus_dout |
| push | output | 3 | FIFO write pulse per path |
| push_data | output | 8 | Byte written to the FIFO |
| pop | output | 3 | FIFO read pulse per path |
| pop_data | input | 24 | FIFO head byte per path |
| drq | output | 4 | DMA request per ISA channel |
| done | output | 3 | Burst complete pulse per path |
| cfg_err | output | 1 | Two paths routed to the same channel |

## Verification
A request pulse driven at a falling edge shows up on DRQ after the following rising edge. Routing changes show up on `cfg_err` after one rising edge in the same way. The bench therefore samples one time unit after the next falling edge. Byte completion, `done`, `push`, `pop` and the DRQ release are combinational from the strobe's falling level against the registered strobe and DACK. The bench lowers the strobe at a falling edge and samples one time unit later, within the same clock period. It samples again one cycle later to see a queued burst restart. `bus_dout` and `bus_oe` are sampled while the strobe is held high.

// File: rtl/dma_reqctl_pkg.sv
package dma_reqctl_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_BURST  = 2'd1,
    PS_QUEUED = 2'd2
  } path_state_e;
endpackage

// File: rtl/dma_route_map.sv
module dma_route_map #(
  parameter int NPATH = 3,
  parameter int CHW   = 2,
  parameter logic [NPATH*CHW-1:0] DEF_ROUTE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [NPATH*CHW-1:0] wdata,
  output logic [NPATH*CHW-1:0] route,
  output logic [NPATH-1:0]     path_en,
  output logic                 cfg_err
);
  // true when a lower-lettered path already claims the channel of path p
  function automatic logic claimed_below(input logic [NPATH*CHW-1:0] r, input int p);
    logic hit;
    hit = 1'b0;
    for (int q = 0; q < NPATH; q++)
      if (q < p && r[q*CHW +: CHW] == r[p*CHW +: CHW]) hit = 1'b1;
    return hit;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  route <= DEF_ROUTE;
    else if (we) route <= wdata;

  always_comb begin
    for (int p = 0; p < NPATH; p++) path_en[p] = ~claimed_below(route, p);
  end

  assign cfg_err = ~&path_en;
endmodule

// File: rtl/dma_strobe_edge.sv
module dma_strobe_edge #(
  parameter int NISA = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ior,
  input  logic            iow,
  input  logic [NISA-1:0] dack,
  input  logic [DW-1:0]   din,
  output logic            rd_end,
  output logic            wr_end,
  output logic [NISA-1:0] dack_q,
  output logic [DW-1:0]   din_q
);
  logic ior_q, iow_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ior_q  <= 1'b0;
      iow_q  <= 1'b0;
      dack_q <= '0;
      din_q  <= '0;
    end else begin
      ior_q  <= ior;
      iow_q  <= iow;
      dack_q <= dack;
      if (iow) din_q <= din;
    end

  assign rd_end = ior_q & ~ior;
  assign wr_end = iow_q & ~iow;
endmodule

// File: rtl/dma_path_ctl.sv
module dma_path_ctl
  import dma_reqctl_pkg::*;
#(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [LENW-1:0] req_len,
  input  logic            en,
  input  logic            byte_end,
  output logic            busy,
  output logic            last,
  output logic            byte_evt
);
  path_state_e     st_q;
  logic [LENW-1:0] cnt_q;
  logic [LENW-1:0] qlen_q;
  logic            req_ok;

  // remaining bytes minus one, stepped down per counted byte
  function automatic logic [LENW-1:0] step_down(input logic [LENW-1:0] c);
    return c - LENW'(1);
  endfunction

  assign req_ok   = req & en;
  assign busy     = (st_q != PS_IDLE);
  assign byte_evt = byte_end & busy;
  assign last     = byte_evt & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      cnt_q  <= '0;
      qlen_q <= '0;
    end else begin
      unique case (st_q)
        PS_IDLE: if (req_ok) begin
          st_q  <= PS_BURST;
          cnt_q <= req_len;
        end
        PS_BURST: begin
          if (last) begin
            if (req_ok) cnt_q <= req_len;
            else        st_q  <= PS_IDLE;
          end else begin
            if (byte_evt) cnt_q <= step_down(cnt_q);
            if (req_ok) begin
              qlen_q <= req_len;
              st_q   <= PS_QUEUED;
            end
          end
        end
        PS_QUEUED: begin
          if (last) begin
            st_q  <= PS_BURST;
            cnt_q <= qlen_q;
          end else if (byte_evt) cnt_q <= step_down(cnt_q);
        end
        default: st_q <= PS_IDLE;
      endcase
    end
endmodule

// File: rtl/isa_dma_reqctl.sv
module isa_dma_reqctl #(
  parameter int NPATH = 3,
  parameter int NISA  = 4,
  parameter int LENW  = 8,
  parameter int DW    = 8,
  parameter logic [NPATH*$clog2(NISA)-1:0] DEF_ROUTE = 6'b11_01_00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  route_we,
  input  logic [NPATH*$clog2(NISA)-1:0] route_wdata,
  input  logic [NPATH-1:0]      req,
  input  logic [NPATH*LENW-1:0] req_len,
  input  logic [NISA-1:0]       dack,
  input  logic                  ior,
  input  logic                  iow,
  input  logic [DW-1:0]         bus_din,
  output logic [DW-1:0]         bus_dout,
  output logic                  bus_oe,
  output logic [NPATH-1:0]      push,
  output logic [DW-1:0]         push_data,
  output logic [NPATH-1:0]      pop,
  input  logic [NPATH*DW-1:0]   pop_data,
  output logic [NISA-1:0]       drq,
  output logic [NPATH-1:0]      done,
  output logic                  cfg_err
);
  localparam int CHW = $clog2(NISA);

  logic [NPATH*CHW-1:0]  route;
  logic [NPATH-1:0]      path_en;
  logic                  rd_end, wr_end;
  logic [NISA-1:0]       dack_q;
  logic [DW-1:0]         din_q;
  logic [NPATH-1:0]      hit_q, hit_now, byte_end, busy_v, last_v, evt_v;
  logic [NISA*NPATH-1:0] drq_src;

  dma_route_map #(.NPATH(NPATH), .CHW(CHW), .DEF_ROUTE(DEF_ROUTE)) u_route (
    .clk(clk), .rst_n(rst_n), .we(route_we), .wdata(route_wdata),
    .route(route), .path_en(path_en), .cfg_err(cfg_err)
  );

  dma_strobe_edge #(.NISA(NISA), .DW(DW)) u_edge (
    .clk(clk), .rst_n(rst_n), .ior(ior), .iow(iow), .dack(dack), .din(bus_din),
    .rd_end(rd_end), .wr_end(wr_end), .dack_q(dack_q), .din_q(din_q)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [CHW-1:0] rp;
    assign rp          = route[p*CHW +: CHW];
    assign hit_q[p]    = dack_q[rp] & path_en[p];
    assign hit_now[p]  = dack[rp] & path_en[p];
    assign byte_end[p] = (rd_end | wr_end) & hit_q[p];

    dma_path_ctl #(.LENW(LENW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .req(req[p]), .req_len(req_len[p*LENW +: LENW]),
      .en(path_en[p]), .byte_end(byte_end[p]),
      .busy(busy_v[p]), .last(last_v[p]), .byte_evt(evt_v[p])
    );

    assign push[p] = wr_end & evt_v[p];
    assign pop[p]  = rd_end & evt_v[p];
    assign done[p] = last_v[p];

    for (genvar c = 0; c < NISA; c++) begin : g_src
      assign drq_src[c*NPATH + p] = busy_v[p] & ~last_v[p] & path_en[p] & (rp == CHW'(c));
    end
  end

  for (genvar c = 0; c < NISA; c++) begin : g_drq
    assign drq[c] = |drq_src[c*NPATH +: NPATH];
  end

  assign push_data = din_q;

  always_comb begin
    logic sel;
    sel      = 1'b0;
    bus_dout = '0;
    for (int p = 0; p < NPATH; p++)
      if (!sel && hit_now[p] && busy_v[p]) begin
        bus_dout = pop_data[p*DW +: DW];
        sel      = 1'b1;
      end
    bus_oe = ior & sel;
  end
endmodule

// File: rtl/dma_reqctl_chk.sv
module dma_reqctl_chk #(
  parameter int NPATH = 3,
  parameter int NISA  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPATH-1:0]      busy,
  input logic [NPATH-1:0]      last,
  input logic [NPATH-1:0]      push,
  input logic [NPATH-1:0]      pop,
  input logic [NPATH-1:0]      done,
  input logic [NISA*NPATH-1:0] drq_src
);
  for (genvar p = 0; p < NPATH; p++) begin : g_p
    // R3
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] && !last[p] |=> busy[p]);
    // R5
    push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push[p] || pop[p]) |-> busy[p]);
    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done[p] |=> !done[p]);
  end
  for (genvar c = 0; c < NISA; c++) begin : g_c
    // R10
    drq_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drq_src[c*NPATH +: NPATH]));
  end
endmodule

bind isa_dma_reqctl dma_reqctl_chk #(.NPATH(NPATH), .NISA(NISA)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_v), .last(last_v),
  .push(push), .pop(pop), .done(done), .drq_src(drq_src)
);

// File: tb/tb_isa_dma_reqctl.sv
`timescale 1ns/1ps
module tb_isa_dma_reqctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        route_we = 1'b0;
  logic [5:0]  route_wdata = '0;
  logic [2:0]  req = '0;
  logic [23:0] req_len = '0;
  logic [3:0]  dack = '0;
  logic        ior = 1'b0, iow = 1'b0;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout, push_data;
  logic        bus_oe, cfg_err;
  logic [2:0]  push, pop, done;
  logic [23:0] pop_data = 24'hC3_B2_A1;
  logic [3:0]  drq;

  int checks = 0, errors = 0;
  int cur_ch[3] = '{0, 1, 3};
  int m_rem[3]  = '{0, 0, 0};
  bit m_q[3]    = '{0, 0, 0};
  int m_qlen[3] = '{0, 0, 0};

  always #5 clk = ~clk;

  isa_dma_reqctl dut (.*);

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit enabled(input int p);
    for (int q = 0; q < p; q++) if (cur_ch[q] == cur_ch[p]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_drq(input int ch);
    for (int p = 0; p < 3; p++)
      if (enabled(p) && cur_ch[p] == ch && m_rem[p] > 0) return 1;
    return 0;
  endfunction

  task automatic check_all_drq(input string r);
    for (int c = 0; c < 4; c++) check(r, int'(drq[c]), exp_drq(c));
  endtask

  task automatic set_route(input int a, input int b, input int c);
    @(negedge clk);
    route_we = 1'b1;
    route_wdata = {2'(c), 2'(b), 2'(a)};
    @(negedge clk);
    route_we = 1'b0;
    cur_ch = '{a, b, c};
    #1;
    check("R9/R10 cfg_err", int'(cfg_err), int'(!(enabled(1) && enabled(2))));
  endtask

  task automatic do_req(input int p, input int len);
    @(negedge clk);
    req[p] = 1'b1;
    req_len[p*8 +: 8] = 8'(len);
    @(negedge clk);
    req[p] = 1'b0;
    if (enabled(p)) begin
      if (m_rem[p] == 0) m_rem[p] = len + 1;
      else if (!m_q[p]) begin m_q[p] = 1'b1; m_qlen[p] = len; end
    end
    #1;
    check_all_drq("R2/R8 drq after request");
  endtask

  task automatic do_byte(input int p, input bit wr);
    int ch = cur_ch[p];
    bit lastb;
    logic [7:0] d = 8'($urandom);
    @(negedge clk);
    dack[ch] = 1'b1;
    if (wr) begin iow = 1'b1; bus_din = d; end else ior = 1'b1;
    #1;
    if (!wr) begin
      check("R7 bus_oe", int'(bus_oe), 1);
      check("R7 bus_dout", int'(bus_dout), int'(pop_data[p*8 +: 8]));
    end
    @(negedge clk);
    iow = 1'b0; ior = 1'b0;
    #1;
    lastb = (m_rem[p] == 1);
    check("R4 done", int'(done[p]), int'(lastb));
    check("R3/R4 drq at edge", int'(drq[ch]), int'(!lastb));
    check("R6/R7 push", int'(push[p]), int'(wr));
    check("R7 pop", int'(pop[p]), int'(!wr));
    if (wr) check("R6 push_data", int'(push_data), int'(d));
    if (lastb) begin
      if (m_q[p]) begin m_rem[p] = m_qlen[p] + 1; m_q[p] = 1'b0; end
      else m_rem[p] = 0;
    end else m_rem[p]--;
    @(negedge clk);
    dack[ch] = 1'b0;
    #1;
    check_all_drq("R3/R8 drq after byte");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4237));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 drq", int'(drq), 0);
    check("R1 done", int'(done), 0);
    check("R1 push/pop", int'({push, pop}), 0);
    check("R1 cfg_err", int'(cfg_err), 0);

    // R1 default routing, R2/R3 a three-byte write burst on path C
    do_req(2, 2);
    check("R1 path C on channel 3", int'(drq), 4'b1000);
    for (int i = 0; i < 3; i++) do_byte(2, 1'b1);

    // R5 stray strobes: no DACK, and DACK on an idle channel
    @(negedge clk); iow = 1'b1;
    @(negedge clk); iow = 1'b0; #1;
    check("R5 no dack push", int'(push), 0);
    check("R5 no dack done", int'(done), 0);
    @(negedge clk); dack[0] = 1'b1; ior = 1'b1;
    @(negedge clk); ior = 1'b0; #1;
    check("R5 idle channel pop", int'(pop), 0);
    @(negedge clk); dack[0] = 1'b0;

    // R8 queued request, third request ignored
    do_req(0, 1);
    do_byte(0, 1'b0);
    do_req(0, 0);
    do_req(0, 5);
    while (m_rem[0] > 0) do_byte(0, 1'b0);

    // R11 full duplex on channels 0 and 1
    do_req(0, 3);
    do_req(1, 2);
    for (int i = 0; i < 4; i++) begin
      do_byte(0, 1'b1);
      if (m_rem[1] > 0) do_byte(1, 1'b0);
    end

    // R9 reroute path A to channel 2
    set_route(2, 1, 3);
    do_req(0, 0);
    check("R9 path A on channel 2", int'(drq), 4'b0100);
    do_byte(0, 1'b1);

    // R10 collision: B and C both on channel 1
    set_route(0, 1, 1);
    do_req(2, 3);
    check("R10 loser ignored", int'(drq), 0);
    do_req(1, 1);
    check("R10 lower path keeps channel", int'(drq), 4'b0010);
    while (m_rem[1] > 0) do_byte(1, 1'b1);
    set_route(0, 1, 3);

    // constrained random bursts on the default routing
    for (int it = 0; it < 40; it++) begin
      int p = $urandom_range(0, 2);
      do_req(p, $urandom_range(0, 4));
      if ($urandom_range(0, 1) == 1) begin
        do_byte(p, 1'($urandom));
        do_req(p, $urandom_range(0, 3));
        if ($urandom_range(0, 3) == 0) do_req(p, 7);
      end
      while (m_rem[p] > 0) do_byte(p, 1'($urandom));
      check("R3 idle after bursts", int'(drq), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule